// File: doc/BRIEF.md
# Dual-Speed Single-Wire Bus Slot Front End

This block sits on the slave side of a single-wire, open-drain bus on which every device and the master can only pull the line low. A resistor provides the high level. The block samples the synchronised line against a time-base strobe (`tick`). From the length of each low period it tells bus resets apart from bit slots. It answers each reset with a presence pulse and turns write slots into received bits. When the command layer asks it to send a 0, it holds the line low through the sampling point of a read slot.

The block has two speed modes. A pulse on `od_set` from the command layer selects the fast mode. In fast mode every slave-side timing is shorter by the factor `OD_DIV`. A very long reset always returns the block to regular speed. A reset that is only long enough for fast mode keeps it fast. All durations are parameters in ticks. The default is 8 ticks per microsecond, so fast-mode timings keep sub-microsecond resolution. The command layer serialises bytes least significant bit first, one bit per `rx_valid` strobe or transmit slot.

Top module: `owire_slot_front`

## Requirements
- R1: After reset, `pull_low`, `rx_valid`, `rst_seen` and `od_mode` are all 0.
- R2: A falling edge on the line starts a slot. A sample point of 240 ticks (30 µs) after it at regular speed, or 30 ticks in fast mode, produces a one-cycle `rx_valid` pulse. `rx_bit` then holds the line level at that point (low = 0, high = 1).
- R3: When `tx_en` is 1 and `tx_bit` is 0 at the falling edge, `pull_low` rises within a few cycles. It stays high until the sample point, so the bit reads as 0. When `tx_bit` is 1, the line is not pulled.
- R4: A low period of at least 3840 ticks (480 µs) gives a one-cycle `rst_seen` pulse when the line rises. It also clears `od_mode`.
- R5: In fast mode, a low period of at least 384 ticks (48 µs) but shorter than 3840 ticks is a reset: `rst_seen` pulses and `od_mode` stays 1.
- R6: At regular speed, a low period longer than the sample point but shorter than 3840 ticks is only a slot: no `rst_seen` and no presence pulse.
- R7: After `rst_seen`, the block waits 240 ticks and then drives `pull_low` for 960 ticks. In fast mode the values are 30 and 120 ticks.
- R8: A falling edge that comes less than 8 ticks (1 µs) after the line went high starts no slot. It produces no `rx_valid` and no pull.
- R9: A one-cycle pulse on `od_set` sets `od_mode` in the next cycle, and the fast timings then apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base strobe, one clock wide, `TICKS_PER_US` per microsecond |
| line_in | input | 1 | Level of the bus line (asynchronous) |
| od_set | input | 1 | Pulse from the command layer selecting fast mode |
| tx_en | input | 1 | The next slot is a read slot answered by this block |
| tx_bit | input | 1 | Bit to send in the next read slot |
| pull_low | output | 1 | Drive the line low (open-drain enable) |
| rx_valid | output | 1 | One-cycle strobe at each slot's sample point |
| rx_bit | output | 1 | Line level taken at the sample point |
| rst_seen | output | 1 | One-cycle strobe when a bus reset ends |
| od_mode | output | 1 | 1 while fast mode is active |

## Verification
A line edge reaches the slot engine after two synchroniser stages and an edge register, about three cycles. Every timed result then follows a whole number of ticks, with one more register stage on the outputs. The bench uses a tick every second clock. It records the cycle at which the stimulus was driven and the cycle at which `rx_valid`, `pull_low` or `rst_seen` changed. Each measured distance must lie within a few cycles of twice the required tick count. Results that must be absent are checked only after a wait longer than the longest window in which they could have appeared.

// File: rtl/owire_pkg.sv
// Shared types for the single-wire slot front end.
// Assumes: nothing beyond the SV standard.
package owire_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // line released or recovering, waiting for a falling edge
        ST_SLOT,   // slot running up to its sample point
        ST_TAIL,   // line still low after the sample point: possible reset
        ST_PWAIT,  // reset seen, waiting before presence
        ST_PDRV,   // driving the presence pulse
        ST_PEND    // presence released, waiting for the line to go high
    } slot_state_e;

endpackage

// File: rtl/owire_line_sync.sv
// Brings the asynchronous bus level into the clock domain and flags edges.
// Assumes: the idle bus is high, so every stage resets to 1.
module owire_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic level,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw level through the synchroniser chain.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], line_async};
            end
        end
    endgenerate

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign level = sync_q[STAGES-1];
    assign fall  = prev_q & ~sync_q[STAGES-1];
    assign rise  = ~prev_q & sync_q[STAGES-1];
endmodule

// File: rtl/owire_tick_timer.sv
// Saturating tick counter with synchronous clear.
// Assumes: clear has priority over counting; holds at MAXV.
module owire_tick_timer #(
    parameter int MAXV = 3840,
    localparam int CW = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    // Count ticks up to the limit, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cnt <= '0;
        else if (clr)                             cnt <= '0;
        else if (tick && (32'(cnt) != MAXV))      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/owire_slot_fsm.sv
// Slot engine: classifies low periods, samples bits, drives read zeros and
// presence, and tracks the speed mode.
// Assumes: line level and edges are already synchronised; lo_cnt is a
// saturating tick count cleared by lo_clr; hi_ok means recovery time met.
module owire_slot_fsm
    import owire_pkg::*;
#(
    parameter int CW       = 12,
    parameter int SAMP_REG = 240,
    parameter int SAMP_OD  = 30,
    parameter int RST_REG  = 3840,
    parameter int RST_OD   = 384,
    parameter int PW_REG   = 240,
    parameter int PW_OD    = 30,
    parameter int PL_REG   = 960,
    parameter int PL_OD    = 120
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    input  logic          fall,
    input  logic          rise,
    input  logic          hi_ok,
    input  logic          tx_en,
    input  logic          tx_bit,
    input  logic          od_set,
    input  logic [CW-1:0] lo_cnt,
    output logic          lo_clr,
    output logic          pull,
    output logic          rx_valid,
    output logic          rx_bit,
    output logic          rst_seen,
    output logic          od_mode
);
    slot_state_e state;
    logic pull_q, od_q, slot_ok_q, broke_q;
    int   samp_t, pw_t, pl_t;
    logic hit_samp, hit_pw, hit_pl, long_low, od_low;

    // Pick the timing set for the current speed mode.
    always_comb begin
        samp_t = od_q ? SAMP_OD : SAMP_REG;
        pw_t   = od_q ? PW_OD   : PW_REG;
        pl_t   = od_q ? PL_OD   : PL_REG;
    end

    // Decode the timer against the mode's thresholds.
    always_comb begin
        hit_samp = tick && (32'(lo_cnt) == samp_t - 1);
        hit_pw   = tick && (32'(lo_cnt) == pw_t - 1);
        hit_pl   = tick && (32'(lo_cnt) == pl_t - 1);
        long_low = 32'(lo_cnt) >= RST_REG;
        od_low   = od_q && (32'(lo_cnt) >= RST_OD);
    end

    // Restart the timer on every phase boundary that times from zero.
    always_comb begin
        unique case (state)
            ST_IDLE:  lo_clr = fall;
            ST_TAIL:  lo_clr = rise;
            ST_PWAIT: lo_clr = hit_pw;
            ST_PDRV:  lo_clr = hit_pl;
            default:  lo_clr = 1'b0;
        endcase
    end

    // Advance the slot engine and its registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pull_q    <= 1'b0;
            rx_valid  <= 1'b0;
            rx_bit    <= 1'b0;
            rst_seen  <= 1'b0;
            od_q      <= 1'b0;
            slot_ok_q <= 1'b0;
            broke_q   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rst_seen <= 1'b0;
            unique case (state)
                ST_IDLE: if (fall) begin
                    state     <= ST_SLOT;
                    slot_ok_q <= hi_ok;
                    broke_q   <= 1'b0;
                    pull_q    <= hi_ok && tx_en && !tx_bit;
                end
                ST_SLOT: begin
                    if (rise) broke_q <= 1'b1;
                    if (hit_samp) begin
                        pull_q   <= 1'b0;
                        rx_valid <= slot_ok_q;
                        rx_bit   <= line;
                        state    <= (line || rise || broke_q) ? ST_IDLE : ST_TAIL;
                    end
                end
                ST_TAIL: if (rise) begin
                    if (long_low || od_low) begin
                        rst_seen <= 1'b1;
                        state    <= ST_PWAIT;
                        if (long_low) od_q <= 1'b0;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_PWAIT: if (hit_pw) begin
                    pull_q <= 1'b1;
                    state  <= ST_PDRV;
                end
                ST_PDRV: if (hit_pl) begin
                    pull_q <= 1'b0;
                    state  <= ST_PEND;
                end
                ST_PEND: if (line) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
            if (od_set) od_q <= 1'b1;
        end
    end

    assign pull    = pull_q;
    assign od_mode = od_q;

    assert_rx_recovered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> slot_ok_q);
    assert_rx_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(tick));
    assert_rst_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |=> !rst_seen);
    assert_od_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_q) |-> rst_seen);
    assert_pres_after_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_PWAIT) |-> rst_seen);
    assert_tx_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pull_q) && state == ST_SLOT) |-> $past(tx_en && !tx_bit));
    assert_od_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(od_set) |-> od_q);
endmodule

// File: rtl/owire_slot_front.sv
// Top of the dual-speed slot front end: synchroniser, low and high timers,
// slot engine. All durations are derived from TICKS_PER_US and OD_DIV.
// Assumes: tick is a one-cycle strobe; line_in may be asynchronous.
module owire_slot_front #(
    parameter int TICKS_PER_US = 8,
    parameter int OD_DIV       = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_in,
    input  logic od_set,
    input  logic tx_en,
    input  logic tx_bit,
    output logic pull_low,
    output logic rx_valid,
    output logic rx_bit,
    output logic rst_seen,
    output logic od_mode
);
    localparam int RST_REG  = 480 * TICKS_PER_US;
    localparam int RST_OD   = 48 * TICKS_PER_US;
    localparam int SAMP_REG = 30 * TICKS_PER_US;
    localparam int SAMP_OD  = SAMP_REG / OD_DIV;
    localparam int PW_REG   = 30 * TICKS_PER_US;
    localparam int PW_OD    = PW_REG / OD_DIV;
    localparam int PL_REG   = 120 * TICKS_PER_US;
    localparam int PL_OD    = PL_REG / OD_DIV;
    localparam int REC      = TICKS_PER_US;
    localparam int LCW      = $clog2(RST_REG + 1);
    localparam int HCW      = $clog2(REC + 1);

    logic           level, fall, rise, lo_clr, hi_ok;
    logic [LCW-1:0] lo_cnt;
    logic [HCW-1:0] hi_cnt;

    owire_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_async(line_in),
        .level(level), .fall(fall), .rise(rise)
    );

    owire_tick_timer #(.MAXV(RST_REG)) u_lo_timer (
        .clk(clk), .rst_n(rst_n), .clr(lo_clr), .tick(tick), .cnt(lo_cnt)
    );

    owire_tick_timer #(.MAXV(REC)) u_hi_timer (
        .clk(clk), .rst_n(rst_n), .clr(!level), .tick(tick), .cnt(hi_cnt)
    );

    // Recovery is met once the line has stayed high for REC ticks.
    always_comb hi_ok = 32'(hi_cnt) >= REC;

    owire_slot_fsm #(
        .CW(LCW), .SAMP_REG(SAMP_REG), .SAMP_OD(SAMP_OD),
        .RST_REG(RST_REG), .RST_OD(RST_OD),
        .PW_REG(PW_REG), .PW_OD(PW_OD), .PL_REG(PL_REG), .PL_OD(PL_OD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(level),
        .fall(fall), .rise(rise), .hi_ok(hi_ok),
        .tx_en(tx_en), .tx_bit(tx_bit), .od_set(od_set),
        .lo_cnt(lo_cnt), .lo_clr(lo_clr), .pull(pull_low),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rst_seen(rst_seen),
        .od_mode(od_mode)
    );

    assert_no_rx_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !rx_valid && !rst_seen && !pull_low);
endmodule

// File: tb/owire_slot_front_tb.sv
// Bench: tick every second clock, a master model pulling the line, a
// vector table of slots, then directed reset, presence and mode tests.
module owire_slot_front_tb;
    localparam int SAMP = 240, SAMP_OD = 30, PW = 240, PL = 960;
    localparam int PW_OD = 30, PL_OD = 120, REC = 8, RST = 3840;
    localparam int NV = 6;
    // per vector: master low ticks, tx mode (0 none, 1 send 0, 2 send 1), expected bit
    localparam int V_LOW [NV] = '{40, 400, 8, 8, 120, 300};
    localparam int V_TX  [NV] = '{0, 0, 1, 2, 0, 0};
    localparam int V_EXP [NV] = '{1, 0, 0, 1, 1, 0};

    logic clk = 0, rst_n = 0, tick = 0, od_set = 0, tx_en = 0, tx_bit = 1;
    logic master_low = 0;
    logic pull_low, rx_valid, rx_bit, rst_seen, od_mode, line_in;
    int cyc = 0, checks = 0, failures = 0;
    int rx_cnt = 0, rx_cyc = 0, rst_cnt = 0, rst_cyc = 0;
    int pr_cnt = 0, pr_cyc = 0, pf_cyc = 0;
    logic rx_last = 0, pull_prev = 0, done = 0;

    assign line_in = ~(master_low | pull_low);

    owire_slot_front u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
        .od_set(od_set), .tx_en(tx_en), .tx_bit(tx_bit),
        .pull_low(pull_low), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .rst_seen(rst_seen), .od_mode(od_mode)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial forever begin
        @(negedge clk); tick = ~tick;
    end

    // Observe outputs half a cycle after they change.
    always @(negedge clk) begin
        if (rx_valid) begin rx_cnt++; rx_last = rx_bit; rx_cyc = cyc; end
        if (rst_seen) begin rst_cnt++; rst_cyc = cyc; end
        if (pull_low && !pull_prev) begin pr_cnt++; pr_cyc = cyc; end
        if (!pull_low && pull_prev) pf_cyc = cyc;
        pull_prev = pull_low;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    // Master holds the line low for low_t ticks; returns the release cycle.
    task automatic pulse(input int low_t, output int t0, output int trel);
        @(negedge clk);
        master_low = 1; t0 = cyc;
        wait_ticks(low_t);
        master_low = 0; trel = cyc;
    endtask

    task automatic slot(input int low_t, input int txm, input int expb,
                        input int samp, input int len, input string tag);
        int rx0, pr0, t0, trel;
        rx0 = rx_cnt; pr0 = pr_cnt;
        tx_en = (txm != 0); tx_bit = (txm != 1);
        pulse(low_t, t0, trel);
        wait_ticks(len - low_t + 2 * REC);
        tx_en = 0; tx_bit = 1;
        check(rx_cnt == rx0 + 1, {tag, " strobe count"}, rx_cnt - rx0, 1);
        check(rx_last == expb[0], {tag, " bit"}, rx_last, expb);
        check(rx_cyc - t0 >= 2 * samp - 2 && rx_cyc - t0 <= 2 * samp + 8,
              {tag, " sample delay"}, rx_cyc - t0, 2 * samp);
        if (txm == 1)
            check(pr_cnt == pr0 + 1 && pf_cyc - pr_cyc >= 2 * samp - 2
                  && pf_cyc - pr_cyc <= 2 * samp + 2,
                  {tag, " R3 pull width"}, pf_cyc - pr_cyc, 2 * samp);
        else
            check(pr_cnt == pr0, {tag, " R3 no pull"}, pr_cnt - pr0, 0);
    endtask

    task automatic bus_reset(input int low_t, input int pw, input int pl,
                             input int exp_od, input string tag);
        int rs0, t0, trel;
        rs0 = rst_cnt;
        pulse(low_t, t0, trel);
        wait_ticks(pw + pl + 2 * REC + 8);
        check(rst_cnt == rs0 + 1, {tag, " rst_seen"}, rst_cnt - rs0, 1);
        check(od_mode == exp_od[0], {tag, " od_mode"}, od_mode, exp_od);
        check(pr_cyc - trel >= 2 * pw - 2 && pr_cyc - trel <= 2 * pw + 8,
              {tag, " R7 presence delay"}, pr_cyc - trel, 2 * pw);
        check(pf_cyc - pr_cyc >= 2 * pl - 2 && pf_cyc - pr_cyc <= 2 * pl + 2,
              {tag, " R7 presence width"}, pf_cyc - pr_cyc, 2 * pl);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        finish_run();
    end

    initial begin
        int rs0, rx0, pr0, t0, trel;
        repeat (4) @(negedge clk);
        rst_n = 1;
        wait_ticks(2 * REC);
        // R1: quiet after reset
        check(pull_low == 0, "R1 pull_low", pull_low, 0);
        check(od_mode == 0, "R1 od_mode", od_mode, 0);
        check(rx_cnt == 0, "R1 rx_valid", rx_cnt, 0);
        check(rst_cnt == 0, "R1 rst_seen", rst_cnt, 0);

        // R2, R3: table of regular-speed slots
        for (int i = 0; i < NV; i++)
            slot(V_LOW[i], V_TX[i], V_EXP[i], SAMP, 480, "R2 regular slot");

        // R4, R7: long reset at regular speed
        bus_reset(3900, PW, PL, 0, "R4 regular reset");

        // R6: long-ish low at regular speed is only a slot
        rs0 = rst_cnt; pr0 = pr_cnt; rx0 = rx_cnt;
        pulse(2000, t0, trel);
        wait_ticks(PW + PL + 2 * REC);
        check(rst_cnt == rs0, "R6 no reset", rst_cnt - rs0, 0);
        check(pr_cnt == pr0, "R6 no presence", pr_cnt - pr0, 0);
        check(rx_cnt == rx0 + 1 && rx_last == 0, "R6 read as 0", rx_cnt - rx0, 1);

        // R8: slot started before recovery is ignored
        rx0 = rx_cnt; pr0 = pr_cnt;
        tx_en = 1; tx_bit = 0;
        pulse(400, t0, trel);
        wait_ticks(2);
        pulse(40, t0, trel);
        wait_ticks(480);
        tx_en = 0; tx_bit = 1;
        check(rx_cnt == rx0 + 1, "R8 runt slot not strobed", rx_cnt - rx0, 1);
        check(pr_cnt == pr0 + 1, "R8 runt slot not pulled", pr_cnt - pr0, 1);
        slot(40, 0, 1, SAMP, 480, "R8 slot after recovery");

        // R9: enter fast mode
        @(negedge clk); od_set = 1;
        @(negedge clk); od_set = 0;
        @(negedge clk);
        check(od_mode == 1, "R9 od_mode set", od_mode, 1);
        slot(2, 0, 1, SAMP_OD, 100, "R9 fast slot one");
        slot(50, 0, 0, SAMP_OD, 100, "R9 fast slot zero");
        slot(2, 1, 0, SAMP_OD, 100, "R9 fast read zero");

        // R5, R7: short reset keeps fast mode, fast presence timing
        bus_reset(500, PW_OD, PL_OD, 1, "R5 fast reset");

        // R4: long reset from fast mode drops to regular
        bus_reset(3900, PW, PL, 0, "R4 reset leaves fast mode");
        slot(120, 0, 1, SAMP, 480, "R4 regular slot after drop");

        finish_run();
    end
endmodule